// File: doc/BRIEF.md
# Ping-Pong Acquisition Buffer Controller

This block records measurement groups into a dual-port memory split into two equal regions that are filled in turn. A group is four 16-bit words: azimuth angle, roll angle, azimuth tracking error and roll tracking error. One group is captured per acquisition event, nominally every 5 ms. A pulse on `acq_strobe` opens a capture window. The four words of the group then arrive on a valid/ready word stream.

When the region being written holds its full count of groups (1000 by default), the controller raises a host interrupt that names the full region. Writing then moves on to the other region. The interrupt stays up until the host acknowledges it. If the writer fills a second region while the interrupt is still pending, a sticky overrun flag is set and recording carries on.

The host reads through an independent request/response port. It can drain the completed region while the writer keeps filling the other one. Read traffic never holds up the writer.

Back-pressure rules:
- Word stream: a word moves only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low outside a capture window, so a source must hold its word until a strobe opens the window.
- Read requests: a request is taken only when `rd_req_ready` is high.
- Read responses: a response is held, unchanged, for as long as `rd_resp_ready` is low.

Top module: `pingpong_acq_ctrl`

## Requirements
- R1: While `rst_n` is low, `irq`, `overrun`, `in_ready` and `rd_resp_valid` are 0. After reset, writing starts at region 0, group 0, word 0.
- R2: A strobe seen while no capture is open sets `in_ready` high on the next cycle. `in_ready` stays high until WORDS_PER_GROUP words have been accepted, and falls on the cycle after the last one. A strobe during a capture is ignored. `in_valid` while `in_ready` is low stores nothing.
- R3: Word k of group g written to region r lands at host word address r*GROUPS*4 + g*4 + k (4000 to 7999 is region 1 by default). Word order within a group is k=0 azimuth, k=1 roll, k=2 azimuth error, k=3 roll error.
- R4: On the cycle after the last word of the last group of region r is accepted, `irq` is 1 and `irq_region` equals r. The next accepted word goes to group 0 of the other region.
- R5: `irq` stays high until a cycle in which `host_ack` is 1, and is 0 on the following cycle. If a region fills in the same cycle as the acknowledge, `irq` stays 1 and `irq_region` names the newly filled region.
- R6: If a region fills while `irq` is high and `host_ack` is 0, then `overrun` is 1 from the next cycle until reset. Recording is not paused.
- R7: `rd_req_ready` equals `!rd_resp_valid || rd_resp_ready`. An accepted request yields `rd_resp_valid` = 1 on the next cycle, carrying the word at `rd_req_addr`.
- R8: While `rd_resp_valid` is 1 and `rd_resp_ready` is 0, the response stays valid and `rd_resp_data` does not change.
- R9: A read of any address at or above 2*GROUPS*4 returns 0.
- R10: A read of the address being written in the same cycle returns the previous contents. `in_ready` and stored data do not depend on read traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_strobe | input | 1 | Opens a group capture window |
| in_valid | input | 1 | Word stream valid |
| in_ready | output | 1 | Word stream ready (capture window open) |
| in_data | input | DATA_W | Word stream data |
| host_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Region-full interrupt |
| irq_region | output | 1 | Index of the full region |
| overrun | output | 1 | Sticky: a region filled before the previous one was acknowledged |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request ready |
| rd_req_addr | input | ADDR_W | Host word address |
| rd_resp_valid | output | 1 | Read response valid |
| rd_resp_ready | input | 1 | Read response ready |
| rd_resp_data | output | DATA_W | Read response data |

## Verification
The hardest state to reach is the collision of a region-full event with a pending interrupt. It has two outcomes: an overrun when no acknowledge is present, and a silent re-arm when the acknowledge lands in the same cycle. The bench shrinks a region to three groups so regions fill every few dozen cycles. One phase withholds acknowledges entirely to force the overrun. Other phases pulse acknowledges at random, so some of them coincide with a fill. Reads hit random addresses, including the word being written and out-of-range ones, while the response channel is throttled. This covers both read-during-write and held responses.

// File: rtl/pp_acq_pkg.sv
package pp_acq_pkg;
  typedef enum logic {
    CAP_IDLE = 1'b0,
    CAP_BUSY = 1'b1
  } cap_state_e;
endpackage

// File: rtl/pp_bank_ram.sv
// One storage region: simple dual-port RAM, one write port and one registered read port.
module pp_bank_ram #(
  parameter int DEPTH = 4000,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // A read of the address written in the same cycle returns the old word (R10).
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_group_writer.sv
// Opens a capture window per strobe, places words linearly in the active region, and flips regions when one fills.
module pp_group_writer
  import pp_acq_pkg::*;
#(
  parameter int GROUPS = 1000,
  parameter int WPG    = 4,
  parameter int DW     = 16,
  localparam int RW    = GROUPS * WPG,
  localparam int BAW   = $clog2(RW),
  localparam int WW    = $clog2(WPG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acq_strobe,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_data,
  output logic           wr_en,
  output logic           wr_bank,
  output logic [BAW-1:0] wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic           full_evt,
  output logic           full_region
);
  cap_state_e     st_q;
  logic [WW-1:0]  word_q;
  logic [BAW-1:0] addr_q;
  logic           region_q;
  logic           accept, grp_done, reg_done;

  assign accept   = in_valid && (st_q == CAP_BUSY);
  assign grp_done = accept && (word_q == WW'(WPG - 1));
  assign reg_done = accept && (addr_q == BAW'(RW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= CAP_IDLE;
      word_q   <= '0;
      addr_q   <= '0;
      region_q <= 1'b0;
    end else begin
      if (st_q == CAP_IDLE) begin
        if (acq_strobe) st_q <= CAP_BUSY;
      end else if (accept) begin
        word_q <= grp_done ? '0 : word_q + 1'b1;
        addr_q <= reg_done ? '0 : addr_q + 1'b1;
        if (grp_done) st_q <= CAP_IDLE;
        if (reg_done) region_q <= ~region_q;
      end
    end
  end

  assign in_ready    = (st_q == CAP_BUSY);
  assign wr_en       = accept;
  assign wr_bank     = region_q;
  assign wr_addr     = addr_q;
  assign wr_data     = in_data;
  assign full_evt    = reg_done;
  assign full_region = region_q;
endmodule

// File: rtl/pp_irq_ctrl.sv
// Region-full interrupt with acknowledge and sticky overrun.
module pp_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic full_evt,
  input  logic full_region,
  input  logic host_ack,
  output logic irq,
  output logic irq_region,
  output logic overrun
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      irq_region <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      if (full_evt) begin
        irq        <= 1'b1;
        irq_region <= full_region;
        if (irq && !host_ack) overrun <= 1'b1;
      end else if (host_ack) begin
        irq <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pp_host_reader.sv
// Host read channel: request/response handshake over the two banks, one-deep held response.
module pp_host_reader #(
  parameter int GROUPS = 1000,
  parameter int WPG    = 4,
  parameter int DW     = 16,
  localparam int RW    = GROUPS * WPG,
  localparam int BAW   = $clog2(RW),
  localparam int AW    = $clog2(2 * RW)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [AW-1:0]       req_addr,
  output logic                resp_valid,
  input  logic                resp_ready,
  output logic [DW-1:0]       resp_data,
  output logic [1:0]          bank_re,
  output logic [BAW-1:0]      bank_raddr,
  input  logic [1:0][DW-1:0]  bank_q
);
  logic          in_b0, in_b1, take;
  logic [AW-1:0] offset;
  logic          sel_q, oor_q;

  assign in_b0     = int'(req_addr) < RW;
  assign in_b1     = !in_b0 && (int'(req_addr) < 2 * RW);
  assign req_ready = !resp_valid || resp_ready;
  assign take      = req_valid && req_ready;
  assign offset    = in_b0 ? req_addr : req_addr - AW'(RW);
  assign bank_raddr = BAW'(offset);
  assign bank_re   = {take && in_b1, take && in_b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      sel_q      <= 1'b0;
      oor_q      <= 1'b0;
    end else if (take) begin
      resp_valid <= 1'b1;
      sel_q      <= in_b1;
      oor_q      <= !(in_b0 || in_b1);
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  assign resp_data = oor_q ? '0 : (sel_q ? bank_q[1] : bank_q[0]);
endmodule

// File: rtl/pingpong_acq_ctrl.sv
module pingpong_acq_ctrl #(
  parameter int GROUPS          = 1000,
  parameter int WORDS_PER_GROUP = 4,
  parameter int DATA_W          = 16,
  localparam int REGION_WORDS   = GROUPS * WORDS_PER_GROUP,
  localparam int BANK_AW        = $clog2(REGION_WORDS),
  localparam int ADDR_W         = $clog2(2 * REGION_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_strobe,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              host_ack,
  output logic              irq,
  output logic              irq_region,
  output logic              overrun,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  input  logic [ADDR_W-1:0] rd_req_addr,
  output logic              rd_resp_valid,
  input  logic              rd_resp_ready,
  output logic [DATA_W-1:0] rd_resp_data
);
  logic                      w_en, w_bank, w_full, w_full_region;
  logic [BANK_AW-1:0]        w_addr, r_addr;
  logic [DATA_W-1:0]         w_data;
  logic [1:0]                bank_re;
  logic [1:0][DATA_W-1:0]    bank_q;

  pp_group_writer #(.GROUPS(GROUPS), .WPG(WORDS_PER_GROUP), .DW(DATA_W)) u_writer (
    .clk(clk), .rst_n(rst_n), .acq_strobe(acq_strobe),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .wr_en(w_en), .wr_bank(w_bank), .wr_addr(w_addr), .wr_data(w_data),
    .full_evt(w_full), .full_region(w_full_region)
  );

  pp_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .full_evt(w_full), .full_region(w_full_region),
    .host_ack(host_ack), .irq(irq), .irq_region(irq_region), .overrun(overrun)
  );

  pp_host_reader #(.GROUPS(GROUPS), .WPG(WORDS_PER_GROUP), .DW(DATA_W)) u_reader (
    .clk(clk), .rst_n(rst_n),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready), .req_addr(rd_req_addr),
    .resp_valid(rd_resp_valid), .resp_ready(rd_resp_ready), .resp_data(rd_resp_data),
    .bank_re(bank_re), .bank_raddr(r_addr), .bank_q(bank_q)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    pp_bank_ram #(.DEPTH(REGION_WORDS), .DW(DATA_W)) u_ram (
      .clk(clk),
      .we(w_en && (w_bank == 1'(b))),
      .waddr(w_addr),
      .wdata(w_data),
      .re(bank_re[b]),
      .raddr(r_addr),
      .rdata(bank_q[b])
    );
  end
endmodule

// File: rtl/pp_acq_checker.sv
module pp_acq_checker #(
  parameter int RW  = 4000,
  parameter int BAW = 12,
  parameter int DW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           acq_strobe,
  input logic           in_ready,
  input logic           host_ack,
  input logic           irq,
  input logic           irq_region,
  input logic           overrun,
  input logic           rd_req_valid,
  input logic           rd_req_ready,
  input logic           rd_resp_valid,
  input logic           rd_resp_ready,
  input logic [DW-1:0]  rd_resp_data,
  input logic           full_evt,
  input logic           full_region,
  input logic           wr_en,
  input logic [BAW-1:0] wr_addr
);
  assert_strobe_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && acq_strobe) |=> in_ready);

  assert_addr_in_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < RW));

  assert_full_raises_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full_evt |=> (irq && (irq_region == $past(full_region))));

  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !host_ack) |=> irq);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && host_ack && !full_evt) |=> !irq);

  assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_evt && irq && !host_ack) |=> overrun);

  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_req_answered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> rd_resp_valid);

  assert_resp_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_resp_valid && !rd_resp_ready) |=> (rd_resp_valid && $stable(rd_resp_data)));
endmodule

bind pingpong_acq_ctrl pp_acq_checker #(.RW(REGION_WORDS), .BAW(BANK_AW), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acq_strobe(acq_strobe), .in_ready(in_ready),
  .host_ack(host_ack), .irq(irq), .irq_region(irq_region), .overrun(overrun),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_resp_valid(rd_resp_valid), .rd_resp_ready(rd_resp_ready),
  .rd_resp_data(rd_resp_data), .full_evt(w_full), .full_region(w_full_region),
  .wr_en(w_en), .wr_addr(w_addr)
);

// File: tb/sim_pingpong_acq_ctrl.sv
`timescale 1ns/1ps
module sim_pingpong_acq_ctrl;
  localparam int G  = 3;
  localparam int W  = 4;
  localparam int DW = 16;
  localparam int RW = G * W;
  localparam int AW = $clog2(2 * RW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq_strobe = 1'b0, in_valid = 1'b0, host_ack = 1'b0;
  logic rd_req_valid = 1'b0, rd_resp_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [AW-1:0] rd_req_addr = '0;
  logic in_ready, irq, irq_region, overrun, rd_req_ready, rd_resp_valid;
  logic [DW-1:0] rd_resp_data;

  always #4 clk = ~clk;

  pingpong_acq_ctrl #(.GROUPS(G), .WORDS_PER_GROUP(W), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .acq_strobe(acq_strobe), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .host_ack(host_ack), .irq(irq),
    .irq_region(irq_region), .overrun(overrun), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_ready(rd_resp_ready),
    .rd_resp_data(rd_resp_data)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Reference model state
  int m_mem [2*RW];
  bit m_wr  [2*RW];
  bit m_cap, m_irq, m_irqr, m_ovr, m_rv, m_rknown;
  int m_word, m_addr, m_region, m_rdata;
  string m_rtag = "R3";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cap = 0; m_irq = 0; m_irqr = 0; m_ovr = 0; m_rv = 0;
      m_word = 0; m_addr = 0; m_region = 0; m_rknown = 0;
    end else begin
      bit full; int fr; int widx;
      full = 0; fr = 0;
      widx = (m_cap && in_valid) ? m_region * RW + m_addr : -1;
      // Read sees memory before this cycle's write (R10)
      if (rd_req_valid && (!m_rv || rd_resp_ready)) begin
        int a;
        a = int'(rd_req_addr);
        m_rv = 1;
        if (a >= 2 * RW) begin
          m_rdata = 0; m_rknown = 1; m_rtag = "R9";
        end else begin
          m_rdata = m_mem[a]; m_rknown = m_wr[a];
          m_rtag = (a == widx) ? "R10" : "R3";
        end
      end else if (rd_resp_ready) begin
        m_rv = 0;
      end else if (m_rv) begin
        m_rtag = "R8";
      end
      if (m_cap && in_valid) begin
        m_mem[widx] = int'(in_data);
        m_wr[widx]  = 1;
        if (m_addr == RW - 1) begin
          full = 1; fr = m_region; m_addr = 0; m_region = 1 - m_region;
        end else m_addr++;
        if (m_word == W - 1) begin
          m_word = 0; m_cap = 0;
        end else m_word++;
      end else if (!m_cap && acq_strobe) begin
        m_cap = 1;
      end
      if (full) begin
        if (m_irq && !host_ack) m_ovr = 1;
        m_irq = 1; m_irqr = fr[0];
      end else if (host_ack) begin
        m_irq = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(in_ready == m_cap, "R2", "in_ready", in_ready, m_cap);
    chk(irq == m_irq, "R5", "irq", irq, m_irq);
    if (m_irq) chk(irq_region == m_irqr, "R4", "irq_region", irq_region, m_irqr);
    chk(overrun == m_ovr, "R6", "overrun", overrun, m_ovr);
    chk(rd_resp_valid == m_rv, "R7", "rd_resp_valid", rd_resp_valid, m_rv);
    chk(rd_req_ready == (!m_rv || rd_resp_ready), "R7", "rd_req_ready",
        rd_req_ready, !m_rv || rd_resp_ready);
    if (m_rv && m_rknown)
      chk(int'(rd_resp_data) == m_rdata, m_rtag, "rd_resp_data", rd_resp_data, m_rdata);
  endtask

  task automatic check_reset();
    chk(irq == 0, "R1", "irq in reset", irq, 0);
    chk(overrun == 0, "R1", "overrun in reset", overrun, 0);
    chk(in_ready == 0, "R1", "in_ready in reset", in_ready, 0);
    chk(rd_resp_valid == 0, "R1", "rd_resp_valid in reset", rd_resp_valid, 0);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 0; acq_strobe = 0; in_valid = 0; host_ack = 0; rd_req_valid = 0;
    @(negedge clk);
    check_reset();
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run(input int n, input int ps, input int pv, input int pa,
                     input int pq, input int pr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      acq_strobe    = ($urandom_range(99) < ps);
      in_valid      = ($urandom_range(99) < pv);
      in_data       = DW'($urandom);
      host_ack      = ($urandom_range(99) < pa);
      rd_req_valid  = ($urandom_range(99) < pq);
      rd_req_addr   = AW'($urandom_range(2 * RW + 5));
      rd_resp_ready = ($urandom_range(99) < pr);
    end
  endtask

  initial begin
    for (int i = 0; i < 2 * RW; i++) begin
      m_mem[i] = 0; m_wr[i] = 0;
    end
    apply_reset();
    run(2000, 30, 70, 10, 50, 70);   // mixed traffic, occasional ack/fill overlap (R5)
    apply_reset();                    // overrun cleared by reset (R1)
    run(1500, 40, 80, 0, 50, 60);    // no acknowledges: forces overrun (R6)
    apply_reset();
    run(1500, 30, 70, 40, 70, 20);   // heavy response back-pressure (R8), reads during writes (R10)
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule